// File: doc/BRIEF.md
# Coherency-Gated Priority Bus Arbiter

This block decides which of four requesters drives a shared external bus. The requesters are an external bus-request input, two DMA channels and a CPU. Each requester raises a request line. Each also pulses an end-of-cycle strobe when one of its bus cycles completes, and marks that strobe with a last-of-operand flag when the cycle closes an indivisible transfer. The arbiter answers with a one-hot grant, or with no grant at all when the bus is idle.

A master that holds the bus keeps it for as long as an operand is still in flight. Handover can happen only when the owner reports a cycle end that carries the last flag. The requester decides where its operand boundaries fall. A dual-address DMA move reports its read and its write as separate operands. A DMA channel whose port sizes differ reports each small-port access as its own operand. A multi-operand CPU operation flags each operand separately. The CPU adds one qualifier: the read half of a read-modify-write never ends its ownership, even when that read is flagged last. Fixed priority puts the external request first, then DMA, then the CPU. The order between the two DMA channels follows a programmable level for each channel.

Top module: `bus_arbiter`

## Requirements
- R1: The grant is one-hot or zero at all times, and it is zero after reset. Bit 0 is the external requester, bit 1 is DMA channel 1, bit 2 is DMA channel 2 and bit 3 is the CPU.
- R2: While no grant is held, the grant is updated on every clock edge to the winner among the pending requests, and it stays zero when none is pending.
- R3: Whenever arbitration takes place, the external request wins over both DMA channels, and any DMA request wins over the CPU.
- R4: When both DMA channels request, the channel with the numerically higher level wins. Equal levels give the bus to channel 1.
- R5: While a master holds the bus, the grant does not change on any edge where that owner did not report a cycle end with its last flag. End strobes from non-owners have no effect.
- R6: A CPU cycle end marked as the read half of a read-modify-write keeps the CPU on the bus, even when the last flag is set.
- R7: At the owner's final cycle end, arbitration runs again among the requests pending at that edge. The previous owner takes part. When no request is pending, the bus goes idle.
- R8: Every DMA cycle end that carries the last flag is a handover point. This lets another master take the bus between the read and the write of a dual-address move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req | input | 1 | External bus request |
| ext_end | input | 1 | External master cycle end |
| ext_last | input | 1 | External cycle closes its operand |
| dma_req | input | 2 | DMA requests; bit 0 is channel 1, bit 1 is channel 2 |
| dma_end | input | 2 | DMA cycle end per channel |
| dma_last | input | 2 | DMA cycle closes its operand, per channel |
| dma_lvl1 | input | LVLW | Priority level of DMA channel 1 |
| dma_lvl2 | input | LVLW | Priority level of DMA channel 2 |
| cpu_req | input | 1 | CPU request |
| cpu_end | input | 1 | CPU cycle end |
| cpu_last | input | 1 | CPU cycle closes its operand |
| cpu_rmw_rd | input | 1 | CPU cycle is the read half of a read-modify-write |
| grant | output | 4 | One-hot bus grant |

## Verification
The bench starts from an idle bus and sweeps all sixteen request combinations against every pair of 2-bit channel levels. This separates fixed priority from level-based ordering, and it shows whether equal levels fall back to channel 1. After each grant, a final cycle end with no requests left shows that the bus returns to idle. Directed sequences then hold competing requests pending through several kinds of cycle end: a four-cycle CPU operand, a read-modify-write read flagged last, strobes from non-owners, and the read half of a DMA move. Together they tell a true operand boundary apart from every cycle end that must not move the grant.

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int LVLW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_req,
  input  logic            ext_end,
  input  logic            ext_last,
  input  logic [1:0]      dma_req,
  input  logic [1:0]      dma_end,
  input  logic [1:0]      dma_last,
  input  logic [LVLW-1:0] dma_lvl1,
  input  logic [LVLW-1:0] dma_lvl2,
  input  logic            cpu_req,
  input  logic            cpu_end,
  input  logic            cpu_last,
  input  logic            cpu_rmw_rd,
  output logic [3:0]      grant
);

  logic [3:0] own_q;
  logic [3:0] pick;
  logic       at_edge;

  wire idle      = (own_q == 4'b0000);
  wire ch1_first = (dma_lvl1 >= dma_lvl2);

  assign at_edge = (own_q[0] & ext_end     & ext_last)
                 | (own_q[1] & dma_end[0]  & dma_last[0])
                 | (own_q[2] & dma_end[1]  & dma_last[1])
                 | (own_q[3] & cpu_end     & cpu_last & ~cpu_rmw_rd);

  always_comb begin
    pick = 4'b0000;
    if (ext_req)                     pick = 4'b0001;
    else if (&dma_req)               pick = ch1_first ? 4'b0010 : 4'b0100;
    else if (dma_req[0])             pick = 4'b0010;
    else if (dma_req[1])             pick = 4'b0100;
    else if (cpu_req)                pick = 4'b1000;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                own_q <= 4'b0000;
    else if (idle || at_edge)  own_q <= pick;
  end

  assign grant = own_q;

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 4'b0000) && !ext_req && (dma_req == 2'b00) && !cpu_req
    |=> (grant == 4'b0000));

  a_r3_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 4'b0000) && ext_req |=> grant[0]);

  a_r5_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != 4'b0000) && !ext_end && (dma_end == 2'b00) && !cpu_end
    |=> $stable(grant));

  a_r6_rmw_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    grant[3] && cpu_rmw_rd |=> grant[3]);

  a_r8_dma_handover: assert property (@(posedge clk) disable iff (!rst_n)
    grant[1] && dma_end[0] && dma_last[0] && ext_req |=> grant[0]);

endmodule

// File: tb/tb_bus_arbiter.sv
module tb_bus_arbiter;
  localparam int LW = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic ext_req = 0, ext_end = 0, ext_last = 0;
  logic [1:0] dma_req = 0, dma_end = 0, dma_last = 0;
  logic [LW-1:0] dma_lvl1 = 0, dma_lvl2 = 0;
  logic cpu_req = 0, cpu_end = 0, cpu_last = 0, cpu_rmw_rd = 0;
  logic [3:0] grant;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  bus_arbiter #(.LVLW(LW)) dut (
    .clk(clk), .rst_n(rst_n),
    .ext_req(ext_req), .ext_end(ext_end), .ext_last(ext_last),
    .dma_req(dma_req), .dma_end(dma_end), .dma_last(dma_last),
    .dma_lvl1(dma_lvl1), .dma_lvl2(dma_lvl2),
    .cpu_req(cpu_req), .cpu_end(cpu_end), .cpu_last(cpu_last),
    .cpu_rmw_rd(cpu_rmw_rd), .grant(grant));

  task automatic chk(input string tag, input logic [3:0] exp);
    checks++;
    if (grant !== exp) begin
      fails++;
      $display("FAIL %s: grant=%b expected=%b at %0t", tag, grant, exp, $time);
    end
  endtask

  function automatic logic [3:0] winner(input logic [3:0] r, input int l1, input int l2);
    if (r[0]) return 4'b0001;
    if (r[1] && r[2]) return (l1 >= l2) ? 4'b0010 : 4'b0100;
    if (r[1]) return 4'b0010;
    if (r[2]) return 4'b0100;
    if (r[3]) return 4'b1000;
    return 4'b0000;
  endfunction

  task automatic set_req(input logic [3:0] r);
    ext_req = r[0]; dma_req = r[2:1]; cpu_req = r[3];
  endtask

  task automatic clr_end();
    ext_end = 0; ext_last = 0; dma_end = 0; dma_last = 0;
    cpu_end = 0; cpu_last = 0; cpu_rmw_rd = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: grant=%b expected=finish", grant);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1 reset", 4'b0000);
    rst_n = 1;
    step();
    chk("R2 idle no request", 4'b0000);

    // R2 R3 R4 R7 sweep from idle
    for (int l1 = 0; l1 < 4; l1++) begin
      for (int l2 = 0; l2 < 4; l2++) begin
        for (int v = 0; v < 16; v++) begin
          logic [3:0] e;
          dma_lvl1 = l1[LW-1:0]; dma_lvl2 = l2[LW-1:0];
          set_req(v[3:0]);
          e = winner(v[3:0], l1, l2);
          step();
          if (v[2:1] == 2'b11 && !v[0]) chk("R4 level order", e);
          else chk("R3 fixed priority", e);
          set_req(4'b0000);
          ext_end = 1; ext_last = 1; dma_end = 2'b11; dma_last = 2'b11;
          cpu_end = 1; cpu_last = 1;
          step();
          clr_end();
          chk("R7 idle after last", 4'b0000);
        end
      end
    end

    // R5: CPU four-cycle operand, ext waiting
    dma_lvl1 = 0; dma_lvl2 = 0;
    set_req(4'b1000);
    step();
    chk("R2 cpu granted", 4'b1000);
    ext_req = 1;
    for (int k = 0; k < 3; k++) begin
      cpu_end = 1;
      step();
      chk("R5 mid-operand hold", 4'b1000);
    end
    ext_end = 1; ext_last = 1; dma_end = 2'b11; dma_last = 2'b11; cpu_end = 0;
    step();
    clr_end();
    chk("R5 non-owner strobes ignored", 4'b1000);
    cpu_end = 1; cpu_last = 1;
    step();
    clr_end();
    chk("R3 ext takes bus at boundary", 4'b0001);

    // R6: read-modify-write
    set_req(4'b1000);
    ext_end = 1; ext_last = 1;
    step();
    clr_end();
    chk("R7 cpu wins after ext done", 4'b1000);
    dma_req = 2'b01;
    cpu_end = 1; cpu_last = 1; cpu_rmw_rd = 1;
    step();
    clr_end();
    chk("R6 rmw read keeps cpu", 4'b1000);
    cpu_end = 1; cpu_last = 1;
    step();
    clr_end();
    chk("R6 dma after rmw write", 4'b0010);

    // R8: dual-address read half hands to higher level channel 2
    dma_lvl1 = 1; dma_lvl2 = 3;
    dma_req = 2'b11; cpu_req = 1;
    dma_end = 2'b01;
    step();
    clr_end();
    chk("R8 no last keeps ch1", 4'b0010);
    dma_end = 2'b01; dma_last = 2'b01;
    step();
    clr_end();
    chk("R8 handover after read half", 4'b0100);

    // R7: owner re-wins when alone
    dma_req = 2'b00;
    dma_end = 2'b10; dma_last = 2'b10;
    step();
    clr_end();
    chk("R7 cpu after dma", 4'b1000);
    cpu_end = 1; cpu_last = 1;
    step();
    clr_end();
    chk("R7 owner re-arbitrates alone", 4'b1000);
    cpu_req = 0;
    cpu_end = 1; cpu_last = 1;
    step();
    clr_end();
    chk("R7 idle when none pending", 4'b0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule